// File: doc/BRIEF.md
# Two-Channel DC Offset Calibration and Removal

This block sits after a two-channel decimation filter and removes the DC offset from 24-bit signed samples. When the active-low reset input goes high, the block runs one calibration cycle. During the cycle it raises a busy flag. It drives a select output that tells the analog side to measure either the internal common-mode reference or the real inputs. It ignores a settling window of frames, then averages a power-of-two number of frames per channel. The two averages become the stored offsets.

After calibration, every frame has its channel's offset subtracted, with saturation. The result can then pass through an optional first-order DC-blocking high-pass stage. The cycle length follows the frame count. A rate-mode pin, sampled when the cycle starts, doubles both the settling window and the averaging window. Output samples are zero while calibration runs.

Top module: `dcal_top`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous), `cal_busy`, `cm_sel`, `out_vld`, `out_l` and `out_r` are 0, and the stored offsets and filter state are cleared.
- R2: At the first clock edge with `rst_n` high, a cycle starts: `cal_busy` is 1 after that edge, and `rate_dbl` is sampled then and held for the whole cycle. Later changes of `rate_dbl` do not alter the cycle length.
- R3: With `rate_dbl` low at start, the cycle spans SETTLE_N + 2^AVG_SHIFT_N frame strobes (512 + 8192 = 8704 by default). `cal_busy` falls at the clock edge that takes the last of them.
- R4: With `rate_dbl` high at start, the cycle spans 2·SETTLE_N + 2^(AVG_SHIFT_N+1) frame strobes (17408 by default).
- R5: Each channel's offset is the sum of its samples from the frames after the settling window, arithmetically shifted right by AVG_SHIFT_N (normal) or AVG_SHIFT_N+1 (double). This is the floor of the mean. Settling-window samples have no effect.
- R6: `cm_sel` is 1 exactly when calibration is busy and `ref_sel_in` is low (common-mode reference measured). It is 0 when `ref_sel_in` is high (analog inputs measured) and whenever calibration is not busy.
- R7: Each `frame_stb` after a cycle has started gives a one-cycle `out_vld` at the next clock edge. If calibration was busy at that strobe, both output samples are 0. Outputs hold between strobes.
- R8: After calibration, with `hpf_on` low, each output is x − offset clamped to [−2^23, 2^23−1], two's complement.
- R9: With `hpf_on` high, the output is y = sat(c − c_prev + y_prev − (y_prev >>> HPF_SHIFT)), where c is the clamped offset-corrected sample. c_prev and y_prev are updated on every post-calibration frame in either mode, and y equals c when the stage is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts calibration |
| frame_stb | input | 1 | One-cycle strobe per sample frame |
| smp_l | input | 24 | Left input sample, signed |
| smp_r | input | 24 | Right input sample, signed |
| rate_dbl | input | 1 | 1 = double-rate mode, sampled at cycle start |
| ref_sel_in | input | 1 | 0 = measure common-mode reference, 1 = measure inputs |
| hpf_on | input | 1 | 1 = DC-blocking stage enabled |
| cal_busy | output | 1 | High while calibration runs |
| cm_sel | output | 1 | High to connect the common-mode reference |
| out_vld | output | 1 | Output sample pair valid |
| out_l | output | 24 | Left corrected sample, signed |
| out_r | output | 24 | Right corrected sample, signed |

## Verification
Calibration is run in both rate modes. The settling frames carry large junk values, so any leak of a settling sample into the average changes the offset. Averaging windows use ramps whose means are not integers, in both signs, and one run uses values near full scale, which separates floor rounding from truncation and catches accumulator overflow. After calibration, a sweep of values including both range extremes checks subtraction and clamping. A filtered sequence with steps, a full-scale swing and on/off toggling of the stage checks the recursion and the state tracking.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
    localparam int SMP_W  = 24;
    localparam int CH_N   = 2;
    localparam int WIDE_W = SMP_W + 4;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_AVG    = 2'd2,
        ST_RUN    = 2'd3
    } seq_st_e;

    function automatic wide_t widen(input smp_t v);
        return {{(WIDE_W-SMP_W){v[SMP_W-1]}}, v};
    endfunction

    // clamp a wide signed value into the sample range
    function automatic smp_t sat_smp(input wide_t v);
        wide_t hi;
        wide_t lo;
        hi = {{(WIDE_W-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
        lo = ~hi;
        if (v > hi)
            return hi[SMP_W-1:0];
        else if (v < lo)
            return lo[SMP_W-1:0];
        else
            return v[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/dcal_seq.sv
// Calibration phase sequencer: idle -> settle -> average -> run.
// SETTLE_N must not exceed 2**AVG_SHIFT_N so the counter width suffices.
module dcal_seq
    import dcal_pkg::*;
#(
    parameter int SETTLE_N    = 512,
    parameter int AVG_SHIFT_N = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic rate_dbl,
    output logic busy,
    output logic active,
    output logic dbl_q,
    output logic acc_en,
    output logic acc_last
);
    localparam int CNT_W = AVG_SHIFT_N + 2;
    localparam logic [CNT_W-1:0] SET_LAST_N = CNT_W'(SETTLE_N - 1);
    localparam logic [CNT_W-1:0] SET_LAST_D = CNT_W'(2 * SETTLE_N - 1);
    localparam logic [CNT_W-1:0] AVG_LAST_N = CNT_W'((2 ** AVG_SHIFT_N) - 1);
    localparam logic [CNT_W-1:0] AVG_LAST_D = CNT_W'((2 ** (AVG_SHIFT_N + 1)) - 1);

    seq_st_e          st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] set_last;
    logic [CNT_W-1:0] avg_last;

    always_comb begin
        set_last = dbl_q ? SET_LAST_D : SET_LAST_N;
        avg_last = dbl_q ? AVG_LAST_D : AVG_LAST_N;
    end

    assign busy     = (st_q == ST_SETTLE) || (st_q == ST_AVG);
    assign active   = (st_q != ST_IDLE);
    assign acc_en   = frame_stb && (st_q == ST_AVG);
    assign acc_last = acc_en && (cnt_q == avg_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            dbl_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    st_q  <= ST_SETTLE;
                    cnt_q <= '0;
                    dbl_q <= rate_dbl;
                end
                ST_SETTLE: begin
                    if (frame_stb) begin
                        if (cnt_q == set_last) begin
                            st_q  <= ST_AVG;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_AVG: begin
                    if (acc_last) begin
                        st_q  <= ST_RUN;
                        cnt_q <= '0;
                    end else if (frame_stb) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R3 / R4: calibration only ends on a frame strobe
    a_r3_end_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(frame_stb));

    // R2: the rate mode is frozen for the length of the cycle
    a_r2_rate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dbl_q));

    // R4: averaging counter never passes its window
    a_r4_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_AVG) |-> (cnt_q <= avg_last));
endmodule

// File: rtl/dcal_avg.sv
// Per-channel accumulator producing the floor-mean offset.
module dcal_avg
    import dcal_pkg::*;
#(
    parameter int AVG_SHIFT_N = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_en,
    input  logic acc_last,
    input  logic dbl,
    input  smp_t smp,
    output smp_t off
);
    localparam int ACC_W = SMP_W + AVG_SHIFT_N + 2;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] sum_nxt;
    logic signed [ACC_W-1:0] mean;
    smp_t                    off_q;

    always_comb begin
        sum_nxt = acc_q + $signed({{(ACC_W-SMP_W){smp[SMP_W-1]}}, smp});
        mean    = dbl ? (sum_nxt >>> (AVG_SHIFT_N + 1)) : (sum_nxt >>> AVG_SHIFT_N);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            off_q <= '0;
        end else if (acc_en) begin
            if (acc_last) begin
                acc_q <= '0;
                off_q <= smp_t'(mean);
            end else begin
                acc_q <= sum_nxt;
            end
        end
    end

    assign off = off_q;

    // R5: offset only changes when an averaged frame arrives
    a_r5_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(off_q));
endmodule

// File: rtl/dcal_chan.sv
// Per-channel offset removal and optional DC-blocking stage.
module dcal_chan
    import dcal_pkg::*;
#(
    parameter int HPF_SHIFT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic live,
    input  logic hpf_on,
    input  smp_t smp,
    input  smp_t off,
    output smp_t y
);
    smp_t  corr;
    smp_t  filt;
    smp_t  y_nxt;
    smp_t  xp_q;
    smp_t  yp_q;
    smp_t  y_q;
    wide_t leak;

    always_comb begin
        corr  = sat_smp(widen(smp) - widen(off));
        leak  = widen(yp_q) >>> HPF_SHIFT;
        filt  = sat_smp(widen(corr) - widen(xp_q) + widen(yp_q) - leak);
        y_nxt = hpf_on ? filt : corr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xp_q <= '0;
            yp_q <= '0;
            y_q  <= '0;
        end else if (stb) begin
            if (live) begin
                y_q  <= y_nxt;
                xp_q <= corr;
                yp_q <= y_nxt;
            end else begin
                y_q  <= '0;
            end
        end
    end

    assign y = y_q;

    // R9: filter memory only moves on post-calibration frames
    a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && live) |=> ($stable(xp_q) && $stable(yp_q)));
endmodule

// File: rtl/dcal_top.sv
module dcal_top
    import dcal_pkg::*;
#(
    parameter int SETTLE_N    = 512,
    parameter int AVG_SHIFT_N = 13,
    parameter int HPF_SHIFT   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_stb,
    input  logic signed [SMP_W-1:0] smp_l,
    input  logic signed [SMP_W-1:0] smp_r,
    input  logic                    rate_dbl,
    input  logic                    ref_sel_in,
    input  logic                    hpf_on,
    output logic                    cal_busy,
    output logic                    cm_sel,
    output logic                    out_vld,
    output logic signed [SMP_W-1:0] out_l,
    output logic signed [SMP_W-1:0] out_r
);
    logic busy;
    logic active;
    logic dbl_q;
    logic acc_en;
    logic acc_last;
    logic vld_q;
    logic stb_act;

    smp_t smp_a [CH_N];
    smp_t off_a [CH_N];
    smp_t y_a   [CH_N];

    dcal_seq #(
        .SETTLE_N   (SETTLE_N),
        .AVG_SHIFT_N(AVG_SHIFT_N)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .rate_dbl (rate_dbl),
        .busy     (busy),
        .active   (active),
        .dbl_q    (dbl_q),
        .acc_en   (acc_en),
        .acc_last (acc_last)
    );

    assign smp_a[0] = smp_l;
    assign smp_a[1] = smp_r;
    assign stb_act  = frame_stb && active;

    for (genvar c = 0; c < CH_N; c++) begin : gen_ch
        dcal_avg #(
            .AVG_SHIFT_N(AVG_SHIFT_N)
        ) u_avg (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_en  (acc_en),
            .acc_last(acc_last),
            .dbl     (dbl_q),
            .smp     (smp_a[c]),
            .off     (off_a[c])
        );

        dcal_chan #(
            .HPF_SHIFT(HPF_SHIFT)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (stb_act),
            .live  (!busy),
            .hpf_on(hpf_on),
            .smp   (smp_a[c]),
            .off   (off_a[c]),
            .y     (y_a[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= 1'b0;
        else
            vld_q <= stb_act;
    end

    assign cal_busy = busy;
    assign cm_sel   = busy && !ref_sel_in;
    assign out_vld  = vld_q;
    assign out_l    = y_a[0];
    assign out_r    = y_a[1];

    // R7: samples emitted for frames taken during calibration are zero
    a_r7_zero_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(cal_busy)) |-> (out_l == '0 && out_r == '0));

    // R7: outputs move only after a frame strobe
    a_r7_hold_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_stb) |-> ($stable(out_l) && $stable(out_r)));

    // R6: reference select never asserted outside calibration
    a_r6_cm_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
        cm_sel |-> cal_busy);

    // R1: nothing valid on the first cycle out of reset
    a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_vld);
endmodule

// File: tb/dcal_top_bench.sv
module dcal_top_bench;
    localparam int SET_N  = 4;
    localparam int SHIFT  = 3;
    localparam int HSHIFT = 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_stb = 1'b0;
    logic signed [23:0] smp_l = '0;
    logic signed [23:0] smp_r = '0;
    logic               rate_dbl = 1'b0;
    logic               ref_sel_in = 1'b0;
    logic               hpf_on = 1'b0;
    logic               cal_busy;
    logic               cm_sel;
    logic               out_vld;
    logic signed [23:0] out_l;
    logic signed [23:0] out_r;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    longint off_m [2];
    longint xp_m  [2];
    longint yp_m  [2];
    longint sum_m [2];

    always #4 clk = ~clk;

    dcal_top #(
        .SETTLE_N   (SET_N),
        .AVG_SHIFT_N(SHIFT),
        .HPF_SHIFT  (HSHIFT)
    ) u_dcal_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .smp_l     (smp_l),
        .smp_r     (smp_r),
        .rate_dbl  (rate_dbl),
        .ref_sel_in(ref_sel_in),
        .hpf_on    (hpf_on),
        .cal_busy  (cal_busy),
        .cm_sel    (cm_sel),
        .out_vld   (out_vld),
        .out_l     (out_l),
        .out_r     (out_r)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat_m(input longint v);
        if (v > 64'sd8388607) return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    task automatic model_clear();
        for (int c = 0; c < 2; c++) begin
            off_m[c] = 0; xp_m[c] = 0; yp_m[c] = 0; sum_m[c] = 0;
        end
    endtask

    task automatic drive_frame(input longint l, input longint r);
        @(negedge clk);
        frame_stb = 1'b1;
        smp_l = 24'(l);
        smp_r = 24'(r);
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    // frame during calibration: outputs must be zero and valid (R7)
    task automatic cal_frame(input longint l, input longint r, input bit in_avg);
        drive_frame(l, r);
        check("R7 valid during cal", longint'(out_vld), 1);
        check("R7 left zero during cal", longint'(out_l), 0);
        check("R7 right zero during cal", longint'(out_r), 0);
        if (in_avg) begin
            sum_m[0] += l;
            sum_m[1] += r;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic live_frame(input longint l, input longint r, input string req);
        longint x [2];
        longint cv, yv;
        longint got [2];
        x[0] = l; x[1] = r;
        drive_frame(l, r);
        got[0] = longint'(out_l);
        got[1] = longint'(out_r);
        check({req, " valid"}, longint'(out_vld), 1);
        for (int c = 0; c < 2; c++) begin
            cv = sat_m(x[c] - off_m[c]);
            if (hpf_on)
                yv = sat_m(cv - xp_m[c] + yp_m[c] - (yp_m[c] >>> HSHIFT));
            else
                yv = cv;
            xp_m[c] = cv;
            yp_m[c] = yv;
            check(req, got[c], yv);
        end
        @(negedge clk);
        check({req, " valid one cycle"}, longint'(out_vld), 0);
        @(negedge clk);
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        longint vals [10];
        model_clear();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy in reset", longint'(cal_busy), 0);
        check("R1 cm_sel in reset", longint'(cm_sel), 0);
        check("R1 valid in reset", longint'(out_vld), 0);
        check("R1 left in reset", longint'(out_l), 0);
        check("R1 right in reset", longint'(out_r), 0);

        // normal-rate calibration
        release_reset();
        check("R2 busy after release", longint'(cal_busy), 1);
        check("R6 cm_sel with ref low", longint'(cm_sel), 1);
        ref_sel_in = 1'b1;
        #1;
        check("R6 cm_sel with ref high", longint'(cm_sel), 0);
        ref_sel_in = 1'b0;
        #1;
        for (int i = 0; i < SET_N + (1 << SHIFT); i++) begin
            bit avg;
            avg = (i >= SET_N);
            if (i == 6) rate_dbl = 1'b1;   // R2: ignored mid-cycle
            if (i == SET_N + (1 << SHIFT) - 1)
                check("R3 busy before last frame", longint'(cal_busy), 1);
            if (avg)
                cal_frame(100 + (i - SET_N), -((i - SET_N) + 1), 1'b1);
            else
                cal_frame(4000000, -4000000, 1'b0);
        end
        rate_dbl = 1'b0;
        check("R3 busy low after 12 frames", longint'(cal_busy), 0);
        check("R6 cm_sel after cal", longint'(cm_sel), 0);
        for (int c = 0; c < 2; c++) off_m[c] = sum_m[c] >>> SHIFT;
        check("R5 expected left offset model", off_m[0], 103);
        check("R5 expected right offset model", off_m[1], -5);

        // R5 offsets seen via a zero input, R8 sweep
        live_frame(0, 0, "R5 offset normal");
        vals = '{1, -1, 103, -5, 8388607, -8388608, -8388500, 12345, -77, 8388600};
        for (int k = 0; k < 10; k++)
            live_frame(vals[k], vals[9 - k], "R8 offset removal");

        // R9 high-pass stage
        hpf_on = 1'b1;
        for (int k = 0; k < 16; k++)
            live_frame(5000 + (k % 4) * 1000, -8388608 + k * 7, "R9 filter");
        live_frame(-8388608, 8388607, "R9 filter swing");
        live_frame(8388607, -8388608, "R9 filter swing");
        hpf_on = 1'b0;
        for (int k = 0; k < 3; k++)
            live_frame(300 * k - 200, 40000, "R9 state while off");
        hpf_on = 1'b1;
        for (int k = 0; k < 5; k++)
            live_frame(-1000 * k, 2000000, "R9 filter resumed");
        hpf_on = 1'b0;

        // R1 reset after live traffic and mid-cycle
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 left cleared", longint'(out_l), 0);
        check("R1 right cleared", longint'(out_r), 0);
        check("R1 busy cleared", longint'(cal_busy), 0);
        model_clear();
        release_reset();
        for (int i = 0; i < 5; i++) cal_frame(999, 999, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 busy low on mid-cycle reset", longint'(cal_busy), 0);
        check("R1 valid low on mid-cycle reset", longint'(out_vld), 0);

        // double-rate calibration
        model_clear();
        rate_dbl = 1'b1;
        release_reset();
        check("R2 busy after double start", longint'(cal_busy), 1);
        for (int i = 0; i < 2 * SET_N + (2 << SHIFT); i++) begin
            bit avg;
            int j;
            avg = (i >= 2 * SET_N);
            j = i - 2 * SET_N;
            if (i == 3) rate_dbl = 1'b0;   // R2: ignored mid-cycle
            if (i == 2 * SET_N + (2 << SHIFT) - 1)
                check("R4 busy before last frame", longint'(cal_busy), 1);
            if (avg)
                cal_frame(7 * j - 50, 8388607 - j, 1'b1);
            else
                cal_frame(-3000000, -3000000, 1'b0);
        end
        check("R4 busy low after 24 frames", longint'(cal_busy), 0);
        for (int c = 0; c < 2; c++) off_m[c] = sum_m[c] >>> (SHIFT + 1);
        live_frame(0, 0, "R5 offset double");
        live_frame(-8388608, -8388608, "R8 clamp after double cal");
        live_frame(8388607, 123, "R8 after double cal");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule